// File: doc/BRIEF.md
# Serial VID Command Receiver

This block is a two-wire serial slave that takes voltage-identification commands from a processor. The commands arrive as an SMBus-style send-byte write: a start condition, an address byte, a data byte, and a stop condition. A fast system clock samples the clock and data lines through synchronizers. The block detects the start and stop conditions on the sampled lines and shifts in the address and the data. It acknowledges by pulling the data line low through an open-drain enable output.

The address carries a fixed three-bit tag and a bitmap with one select bit per rail, so one command can reach any subset of the three rails. The data byte carries an active-low power-save hint and a 7-bit VID code. Each rail keeps its own VID register and its own power-save flag. The bytes it has received wait until a stop condition closes the transaction, and only then are they written to the selected rails. Each rail that receives the write also raises a one-cycle update strobe for the regulator logic downstream.

Top module: `svid_rx`

## Requirements
- R1: After reset, every rail VID output equals the parameter BOOT_VID (default 7'h40), every power-save flag is 1, all update strobes are 0, and the acknowledge enable is 0.
- R2: A write whose address byte has bits 7:5 = 3'b110, bit 0 = 0 (write), and a non-zero rail bitmap receives an acknowledge after the address byte and after the data byte. After the stop, only the selected rails change.
- R3: Rail bitmap mapping in the address byte: bit 3 selects rail 2, bit 2 selects rail 1, and bit 1 selects rail 0. Bytes go MSB first, with address bits 6:0 in byte bits 7:1. One data byte updates every rail whose bit is set.
- R4: Data byte bit 7 is written to the selected rails' psi_n_o flag (0 = power saving allowed, 1 = not allowed). Bits 6:0 are written to the selected rails' VID.
- R5: An address whose bits 7:5 differ from 3'b110 gets no acknowledge, and the rails stay unchanged.
- R6: A read bit (address byte bit 0 = 1) gets no acknowledge, and the rails stay unchanged.
- R7: An address with all three rail bits clear gets no acknowledge. Bus activity up to the next start then has no effect.
- R8: The reserved address bit (byte bit 4) does not affect acceptance or rail selection.
- R9: Rail outputs do not change before the stop condition, even after the data byte has been acknowledged.
- R10: A start condition in the middle of a transaction discards the partial command. A transaction that ends without a stop leaves every rail unchanged.
- R11: The acknowledge enable is 0 while the clock is high for the eighth bit. It is 1 while the clock is high for the ninth bit. It is 0 again after the falling edge that ends the ninth bit.
- R12: Each committed write raises upd_o for exactly one cycle on each selected rail, in the same cycle that the new VID and flag first appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (wired value) |
| sda_oe_o | output | 1 | 1 = pull the data line low (acknowledge) |
| vid_o | output | 21 | Rail VID codes, rail r at bits r*7 +: 7 |
| psi_n_o | output | 3 | Per-rail active-low power-save flag |
| upd_o | output | 3 | Per-rail one-cycle update strobe |

## Verification
A wrong bit counter or wrong sequencer state first appears on sda_oe_o. The acknowledge comes one bit early or late, or it does not come, and this is visible within the same byte in which the fault occurs. A corrupted pending command or bitmap does not change the outputs until the stop: the wrong rail or value then appears on vid_o, psi_n_o and upd_o a few system cycles after the stop is seen. A missing discard on a restart or a missing stop shows as an update strobe that should not occur.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int NUM_RAILS = 3;
  localparam int VID_W     = 7;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = $clog2(BYTE_W + 1);
  localparam logic [2:0] ADDR_TAG = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_HOLD,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/svid_sync.sv
module svid_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/svid_cond_det.sv
module svid_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign rise_o  = scl_s_i & ~scl_q;
  assign fall_o  = ~scl_s_i & scl_q;
  // data edges only count while clock stays high
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/svid_engine.sv
module svid_engine
  import svid_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sda_s_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  output logic                 ack_o,
  output logic                 commit_o,
  output logic [NUM_RAILS-1:0] sel_o,
  output logic [VID_W-1:0]     vid_o,
  output logic                 psi_n_o,
  output rx_state_e            state_o
);
  rx_state_e          state_q;
  logic [BYTE_W-1:0]  sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_RAILS-1:0] sel_q;
  logic               ack_q;
  logic               addr_ok;
  logic               byte_done;

  assign addr_ok   = (sr_q[7:5] == ADDR_TAG) && !sr_q[0] && (|sr_q[1 +: NUM_RAILS]);
  assign byte_done = fall_i && (cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      cnt_q   <= '0;
      sel_q   <= '0;
      ack_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (rise_i && cnt_q < CNT_W'(BYTE_W)) begin
            sr_q  <= {sr_q[BYTE_W-2:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_done) begin
            if (state_q == ST_DATA) begin
              ack_q   <= 1'b1;
              state_q <= ST_DACK;
            end else if (addr_ok) begin
              ack_q   <= 1'b1;
              sel_q   <= sr_q[1 +: NUM_RAILS];
              state_q <= ST_AACK;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_AACK: if (fall_i) begin
          ack_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DACK: if (fall_i) begin
          ack_q   <= 1'b0;
          state_q <= ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  assign commit_o = (state_q == ST_HOLD) && stop_i;
  assign ack_o    = ack_q;
  assign sel_o    = sel_q;
  assign vid_o    = sr_q[VID_W-1:0];
  assign psi_n_o  = sr_q[BYTE_W-1];
  assign state_o  = state_q;
endmodule

// File: rtl/svid_rail_bank.sv
module svid_rail_bank
  import svid_pkg::*;
#(
  parameter logic [VID_W-1:0] BOOT_VID = 7'h40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [NUM_RAILS-1:0]       sel_i,
  input  logic [VID_W-1:0]           vid_i,
  input  logic                       psi_n_i,
  output logic [NUM_RAILS*VID_W-1:0] vid_o,
  output logic [NUM_RAILS-1:0]       psi_n_o,
  output logic [NUM_RAILS-1:0]       upd_o
);
  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [VID_W-1:0] vid_q;
    logic             psi_q;
    logic             upd_q;
    logic             hit;

    assign hit = commit_i & sel_i[r];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vid_q <= BOOT_VID;
        psi_q <= 1'b1;
        upd_q <= 1'b0;
      end else begin
        upd_q <= hit;
        if (hit) begin
          vid_q <= vid_i;
          psi_q <= psi_n_i;
        end
      end
    end

    assign vid_o[r*VID_W +: VID_W] = vid_q;
    assign psi_n_o[r]              = psi_q;
    assign upd_o[r]                = upd_q;
  end
endmodule

// File: rtl/svid_rx.sv
module svid_rx
  import svid_pkg::*;
#(
  parameter logic [VID_W-1:0] BOOT_VID    = 7'h40,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_RAILS*VID_W-1:0] vid_o,
  output logic [NUM_RAILS-1:0]       psi_n_o,
  output logic [NUM_RAILS-1:0]       upd_o
);
  logic scl_s, sda_s;
  logic rise, fall, start, stop;
  logic commit, pend_psi;
  logic [NUM_RAILS-1:0] pend_sel;
  logic [VID_W-1:0]     pend_vid;
  rx_state_e            eng_state;

  svid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );
  svid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  svid_cond_det u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .rise_o(rise), .fall_o(fall), .start_o(start), .stop_o(stop)
  );

  svid_engine u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_s_i(sda_s),
    .rise_i(rise), .fall_i(fall), .start_i(start), .stop_i(stop),
    .ack_o(sda_oe_o), .commit_o(commit), .sel_o(pend_sel),
    .vid_o(pend_vid), .psi_n_o(pend_psi), .state_o(eng_state)
  );

  svid_rail_bank #(.BOOT_VID(BOOT_VID)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .sel_i(pend_sel),
    .vid_i(pend_vid), .psi_n_i(pend_psi),
    .vid_o(vid_o), .psi_n_o(psi_n_o), .upd_o(upd_o)
  );
endmodule

// File: rtl/svid_rx_chk.sv
module svid_rx_chk
  import svid_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       scl_s,
  input logic                       sda_oe_o,
  input logic [NUM_RAILS*VID_W-1:0] vid_o,
  input logic [NUM_RAILS-1:0]       psi_n_o,
  input logic [NUM_RAILS-1:0]       upd_o,
  input rx_state_e                  eng_state
);
  // R12: strobe lasts one cycle
  p_upd_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd_o) |=> !(|upd_o));

  // R9: VID moves only with a strobe
  p_vid_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_o != $past(vid_o)) |-> (|upd_o));

  // R4: flag moves only with a strobe
  p_psi_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psi_n_o != $past(psi_n_o)) |-> (|upd_o));

  // R11: acknowledge edges only while clock is low
  p_ack_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  p_ack_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_s);

  // R7: no acknowledge while idle, ignoring or holding
  p_no_ack_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_state inside {ST_IDLE, ST_SKIP, ST_HOLD}) |-> !sda_oe_o);
endmodule

bind svid_rx svid_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .vid_o(vid_o), .psi_n_o(psi_n_o), .upd_o(upd_o), .eng_state(eng_state)
);

// File: tb/sim_svid_rx.sv
module sim_svid_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [6:0] BOOT = 7'h40;
  localparam int WD_LIMIT = 100000;

  typedef struct packed {
    logic [1:0] rail;
    logic [6:0] vid;
    logic       psi;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe;
  logic [20:0] vid;
  logic [2:0] psi_n, upd, upd_prev;
  int checks = 0, fails = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  svid_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .vid_o(vid), .psi_n_o(psi_n), .upd_o(upd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int rail, input logic [7:0] d);
    exp_t e;
    e.rail = 2'(rail); e.vid = d[6:0]; e.psi = d[7];
    exp_q.push_back(e);
  endtask

  // monitor: pop expected items on each strobe
  initial upd_prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int r = 0; r < 3; r++) begin
        if (upd[r] && upd_prev[r]) chk(0, "R12 strobe longer than one cycle", r, -1);
        if (upd[r] && !upd_prev[r]) begin
          if (exp_q.size() == 0) chk(0, "R10 unexpected update", r, -1);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(e.rail) == r, "R3 rail", r, int'(e.rail));
            chk(vid[r*7 +: 7] == e.vid, "R4 vid", int'(vid[r*7 +: 7]), int'(e.vid));
            chk(psi_n[r] == e.psi, "R4 psi", int'(psi_n[r]), int'(e.psi));
          end
        end
      end
    end
    upd_prev = upd;
  end

  task automatic bus_start();
    sda_m = 1'b0; wclk(2*Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  task automatic send_bit(input logic b, input bit last);
    wclk(Q);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    if (last) chk(sda_oe == 1'b0, "R11 ack early", int'(sda_oe), 0);
    wclk(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == 0);
    wclk(Q);
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    ack = !sda_line;
    wclk(Q);
    scl_m = 1'b0;
    wclk(6);
    chk(sda_oe == 1'b0, "R11 ack held past ninth bit", int'(sda_oe), 0);
  endtask

  task automatic rails_are(input logic [20:0] ev, input logic [2:0] ep, input string tag);
    chk(vid == ev, tag, int'(vid), int'(ev));
    chk(psi_n == ep, tag, int'(psi_n), int'(ep));
  endtask

  initial begin
    bit a1, a2;
    logic [20:0] cur_v;
    logic [2:0]  cur_p;
    wclk(3);
    // R1 reset state
    rails_are({3{BOOT}}, 3'b111, "R1 reset");
    chk(upd == 3'b000, "R1 strobes", int'(upd), 0);
    chk(sda_oe == 1'b0, "R1 ack", int'(sda_oe), 0);
    rst_n = 1'b1;
    wclk(4);

    // R2 single rail 0, psi=0 vid=1A; R9 no change before stop
    bus_start();
    send_byte({7'b110_0_001, 1'b0}, a1);
    send_byte(8'h1A, a2);
    chk(a1, "R2 address ack", int'(a1), 1);
    chk(a2, "R2 data ack", int'(a2), 1);
    rails_are({3{BOOT}}, 3'b111, "R9 before stop");
    push(0, 8'h1A);
    bus_stop();
    rails_are({BOOT, BOOT, 7'h1A}, 3'b110, "R2 only rail 0");

    // R3 rails 1 and 2, psi=1 vid=55
    bus_start();
    send_byte({7'b110_0_110, 1'b0}, a1);
    send_byte({1'b1, 7'h55}, a2);
    chk(a1 && a2, "R3 acks", int'({a1, a2}), 3);
    push(1, 8'hD5); push(2, 8'hD5);
    bus_stop();
    rails_are({7'h55, 7'h55, 7'h1A}, 3'b110, "R3 multi rail");

    // R8 reserved bit set, rail 2, psi=0 vid=22
    bus_start();
    send_byte({7'b110_1_100, 1'b0}, a1);
    send_byte(8'h22, a2);
    chk(a1, "R8 reserved ignored", int'(a1), 1);
    push(2, 8'h22);
    bus_stop();
    rails_are({7'h22, 7'h55, 7'h1A}, 3'b010, "R8 rail 2");
    cur_v = vid; cur_p = psi_n;

    // R5 bad tag
    bus_start();
    send_byte({7'b101_0_111, 1'b0}, a1);
    send_byte(8'h11, a2);
    chk(!a1, "R5 nack", int'(a1), 0);
    bus_stop();
    rails_are(cur_v, cur_p, "R5 unchanged");

    // R6 read bit
    bus_start();
    send_byte({7'b110_0_111, 1'b1}, a1);
    send_byte(8'h12, a2);
    chk(!a1, "R6 nack", int'(a1), 0);
    bus_stop();
    rails_are(cur_v, cur_p, "R6 unchanged");

    // R7 empty bitmap, following byte ignored
    bus_start();
    send_byte({7'b110_0_000, 1'b0}, a1);
    send_byte(8'h13, a2);
    chk(!a1, "R7 nack", int'(a1), 0);
    chk(!a2, "R7 data ignored", int'(a2), 0);
    bus_stop();
    rails_are(cur_v, cur_p, "R7 unchanged");

    // R10 restart in data phase, then full write to rail 0
    bus_start();
    send_byte({7'b110_0_111, 1'b0}, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    bus_restart();
    send_byte({7'b110_0_001, 1'b0}, a1);
    send_byte({1'b1, 7'h2B}, a2);
    chk(a1 && a2, "R10 after restart acks", int'({a1, a2}), 3);
    push(0, 8'hAB);
    bus_stop();
    rails_are({7'h22, 7'h55, 7'h2B}, 3'b011, "R10 restart");
    cur_v = vid; cur_p = psi_n;

    // R10 full command without stop, then restart and abort
    bus_start();
    send_byte({7'b110_0_111, 1'b0}, a1);
    send_byte(8'h00, a2);
    bus_restart();
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    bus_stop();
    rails_are(cur_v, cur_p, "R10 no stop");

    wclk(20);
    chk(exp_q.size() == 0, "R12 missing strobes", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=0", WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule